// File: doc/BRIEF.md
# Sample FIFO with Hysteretic Ready

This block buffers conversion samples between a converter, which writes, and a serial readout path, which reads. It keeps a fill count and shows it as a high part and a low part. It drives an active-low ready output. In the hysteresis mode, ready falls once the fill count climbs to an upper level. It stays low until the count drains to a lower level. Between the two levels it keeps its last state. This stops the readout side from being woken on every sample when the fill level sits near one level.

Overflow and underflow errors are kept on active-low sticky flags. A flag stays low until a one-cycle clear pulse arrives. A test mode replaces converter data with a running count. A powerdown input flushes the buffer and restarts that count. An enable input lets the whole buffer be switched off without losing its contents.

Top module: `hyst_sample_fifo`

## Requirements
- R1: After reset the fill count is 0, `rdy_n`, `ovf_n` and `udf_n` are 1, and `rd_data` is 0.
- R2: With `fifo_en`=1 and `pdwn`=0, an accepted write raises the fill count by one and an accepted read lowers it by one; both together leave it unchanged. Count bit 8 appears on `depth_hi` and bits 7:0 on `depth_lo`, updated at the clock edge that takes the access.
- R3: Samples leave in the order they were written. A read accepted at an edge presents its sample on `rd_data` right after that edge.
- R4: A write while the count equals DEPTH is dropped: the count and the stored samples are unchanged, and `ovf_n` goes to 0.
- R5: A read while the count is 0 leaves `rd_data` at its previous value and the count at 0, and drives `udf_n` to 0.
- R6: `ovf_n` and `udf_n` stay 0 until a cycle with the matching clear input (`ovf_clr` or `udf_clr`) at 1 returns them to 1. A new error in the same cycle as a clear wins, and the flag stays 0.
- R7: With `rdy_mode`=11 and `thr_upper` nonzero, `rdy_n` is 0 in any cycle where the count is at or above `thr_upper`.
- R8: With `rdy_mode`=11 and `thr_lower` nonzero, `rdy_n` returns to 1 when the count falls to or below `thr_lower`. While the count is strictly between the two levels, `rdy_n` keeps its previous value.
- R9: A threshold of 0 disables its own transition. With `thr_upper`=0, `rdy_n` never falls through the upper level. With `thr_lower`=0, `rdy_n` never rises through the lower level.
- R10: For any `rdy_mode` other than 11, `rdy_n` is 0 exactly when the count is nonzero.
- R11: With `fifo_en`=0, writes and reads have no effect on the count, on `rd_data` or on the error flags.
- R12: A cycle with `pdwn`=1 empties the buffer, sets `rdy_n` to 1, clears `rd_data` to 0 and restarts the test count. While `pdwn` is 1, writes and reads are ignored.
- R13: With `test_en`=1, each stored sample equals the previously stored sample plus one, and `wr_data` is ignored. The first such sample after reset or powerdown is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdwn | input | 1 | Powerdown: flush and hold idle |
| fifo_en | input | 1 | Buffer enable |
| test_en | input | 1 | Replace written data with a running count |
| rdy_mode | input | 2 | Ready mode; 11 selects the hysteresis mode |
| thr_upper | input | 9 | Count at which ready falls (0 disables) |
| thr_lower | input | 9 | Count at which ready rises (0 disables) |
| wr_vld | input | 1 | Write request from the converter |
| wr_data | input | 16 | Sample to write |
| rd_en | input | 1 | Read request from the readout side |
| rd_data | output | 16 | Last sample read |
| depth_hi | output | 1 | Fill count bit 8 |
| depth_lo | output | 8 | Fill count bits 7:0 |
| rdy_n | output | 1 | Active-low ready |
| ovf_n | output | 1 | Sticky overflow flag, active low |
| ovf_clr | input | 1 | Clear pulse for `ovf_n` |
| udf_n | output | 1 | Sticky underflow flag, active low |
| udf_clr | input | 1 | Clear pulse for `udf_n` |

## Verification
The bench drives the count up to the upper level and then partly down again. This catches a ready output that follows a single level and rises as soon as the count drops below the upper level. It fills the buffer completely and writes one more sample, then drains the buffer. A design that wrapped its write pointer would read back the dropped marker in place of the oldest sample. It reads from an empty buffer: a design that fetched stale storage would change `rd_data`. It also sends a clear in the same cycle as a new error, which shows whether the error takes priority over the clear. Zero thresholds, a disabled buffer and powerdown with data inside are each tried. A design that compared against a zero level, or that kept counting while disabled, would show it on `rdy_n` or on the count.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int LO_W = 8;
  typedef logic [1:0] rdy_mode_t;
  localparam rdy_mode_t RDY_HYST = 2'b11;
endpackage

// File: rtl/shf_store.sv
module shf_store #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 256,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] wr_word,
  output logic [CNT_W-1:0]  depth,
  output logic [CNT_W-1:0]  depth_nxt,
  output logic              full,
  output logic              empty,
  output logic [DATA_W-1:0] rd_word
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    rd_d  = rd_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      rd_d  = '0;
    end else begin
      if (wr_go) wp_d = wp_q + PTR_W'(1);
      if (rd_go) begin
        rp_d = rp_q + PTR_W'(1);
        rd_d = mem[rp_q];
      end
      if (wr_go && !rd_go)      cnt_d = cnt_q + CNT_W'(1);
      else if (rd_go && !wr_go) cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go && !clr) mem[wp_q] <= wr_word;
  end

  assign depth     = cnt_q;
  assign depth_nxt = cnt_d;
  assign full      = (cnt_q == FULL_CNT);
  assign empty     = (cnt_q == '0);
  assign rd_word   = rd_q;

  // R2: the count never exceeds the capacity
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R12: a powerdown cycle leaves the buffer empty
  a_r12_flush: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/shf_flag.sv
module shf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_n
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b0;
    else if (clr) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end

  assign flag_n = flag_q;

  // R6: a raised flag holds until a clear arrives
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !clr) |=> !flag_q);
  // R6: an error in the same cycle as a clear wins
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !flag_q);
endmodule

// File: rtl/shf_ready.sv
module shf_ready
  import shf_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  rdy_mode_t        mode,
  input  logic [CNT_W-1:0] thr_hi,
  input  logic [CNT_W-1:0] thr_lo,
  input  logic [CNT_W-1:0] depth_nxt,
  output logic             rdy_n
);
  logic rdy_q, rdy_d;
  logic hit_hi, hit_lo;

  assign hit_hi = (thr_hi != '0) && (depth_nxt >= thr_hi);
  assign hit_lo = (thr_lo != '0) && (depth_nxt <= thr_lo);

  always_comb begin
    rdy_d = rdy_q;
    if (clr)                   rdy_d = 1'b1;
    else if (mode != RDY_HYST) rdy_d = (depth_nxt == '0);
    else if (hit_hi)           rdy_d = 1'b0;
    else if (hit_lo)           rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b1;
    else        rdy_q <= rdy_d;
  end

  assign rdy_n = rdy_q;
endmodule

// File: rtl/hyst_sample_fifo.sv
module hyst_sample_fifo
  import shf_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 256,
  localparam int CNT_W  = $clog2(DEPTH) + 1,
  localparam int HI_W   = CNT_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdwn,
  input  logic              fifo_en,
  input  logic              test_en,
  input  logic [1:0]        rdy_mode,
  input  logic [CNT_W-1:0]  thr_upper,
  input  logic [CNT_W-1:0]  thr_lower,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [HI_W-1:0]   depth_hi,
  output logic [LO_W-1:0]   depth_lo,
  output logic              rdy_n,
  output logic              ovf_n,
  input  logic              ovf_clr,
  output logic              udf_n,
  input  logic              udf_clr
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic              live, full, empty;
  logic              wr_go, rd_go, ovf_ev, udf_ev;
  logic [CNT_W-1:0]  depth, depth_nxt;
  logic [DATA_W-1:0] wr_word, last_q, last_d;

  assign live   = fifo_en && !pdwn;
  assign wr_go  = live && wr_vld && !full;
  assign rd_go  = live && rd_en && !empty;
  assign ovf_ev = live && wr_vld && full;
  assign udf_ev = live && rd_en && empty;

  // test mode source: one above the previously stored sample
  assign wr_word = test_en ? (last_q + DATA_W'(1)) : wr_data;

  always_comb begin
    last_d = last_q;
    if (pdwn)       last_d = '0;
    else if (wr_go) last_d = wr_word;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) last_q <= '0;
    else        last_q <= last_d;
  end

  shf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_s), .clr(pdwn), .wr_go(wr_go), .rd_go(rd_go),
    .wr_word(wr_word), .depth(depth), .depth_nxt(depth_nxt),
    .full(full), .empty(empty), .rd_word(rd_data)
  );

  shf_flag u_ovf (.clk(clk), .rst_n(rst_s), .set(ovf_ev), .clr(ovf_clr), .flag_n(ovf_n));
  shf_flag u_udf (.clk(clk), .rst_n(rst_s), .set(udf_ev), .clr(udf_clr), .flag_n(udf_n));

  shf_ready #(.CNT_W(CNT_W)) u_ready (
    .clk(clk), .rst_n(rst_s), .clr(pdwn), .mode(rdy_mode),
    .thr_hi(thr_upper), .thr_lo(thr_lower), .depth_nxt(depth_nxt), .rdy_n(rdy_n)
  );

  assign depth_hi = depth[CNT_W-1:LO_W];
  assign depth_lo = depth[LO_W-1:0];

  // R4: a write into a full buffer raises overflow
  a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_s)
    (live && wr_vld && full && !rd_en) |=> (!ovf_n && full));
  // R5: a read of an empty buffer raises underflow and keeps the data
  a_r5_underflow: assert property (@(posedge clk) disable iff (!rst_s)
    (live && rd_en && empty) |=> (!udf_n && $stable(rd_data)));
  // R11: nothing moves while disabled
  a_r11_disabled: assert property (@(posedge clk) disable iff (!rst_s)
    (!fifo_en && !pdwn) |=> ($stable(depth) && $stable(rd_data)));
  // R7: at or above the upper level, ready is asserted
  a_r7_upper: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rdy_mode) == RDY_HYST && $past(thr_upper) == thr_upper &&
     thr_upper != '0 && depth >= thr_upper) |-> !rdy_n);
  // R10: plain mode follows not-empty
  a_r10_plain: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rdy_mode) != RDY_HYST && !$past(pdwn)) |-> (rdy_n == (depth == '0)));
  // R12: powerdown releases ready
  a_r12_ready_off: assert property (@(posedge clk) disable iff (!rst_s)
    pdwn |=> rdy_n);
endmodule

// File: tb/hyst_sample_fifo_bench.sv
`timescale 1ns/1ps
module hyst_sample_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n, pdwn, fifo_en, test_en, wr_vld, rd_en, ovf_clr, udf_clr;
  logic [1:0]  rdy_mode;
  logic [8:0]  thr_upper, thr_lower;
  logic [15:0] wr_data, rd_data;
  logic [0:0]  depth_hi;
  logic [7:0]  depth_lo;
  logic        rdy_n, ovf_n, udf_n;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  hyst_sample_fifo u_hyst_sample_fifo (
    .clk(clk), .rst_n(rst_n), .pdwn(pdwn), .fifo_en(fifo_en), .test_en(test_en),
    .rdy_mode(rdy_mode), .thr_upper(thr_upper), .thr_lower(thr_lower),
    .wr_vld(wr_vld), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .depth_hi(depth_hi), .depth_lo(depth_lo), .rdy_n(rdy_n),
    .ovf_n(ovf_n), .ovf_clr(ovf_clr), .udf_n(udf_n), .udf_clr(udf_clr)
  );

  function automatic int depth();
    return int'({depth_hi, depth_lo});
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [15:0] d);
    wr_vld = 1'b1; wr_data = d; cyc(); wr_vld = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1; cyc(); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 depth", depth(), 0);
    check("R1 rdy_n", int'(rdy_n), 1);
    check("R1 ovf_n", int'(ovf_n), 1);
    check("R1 udf_n", int'(udf_n), 1);
    check("R1 rd_data", int'(rd_data), 0);
  endtask

  task automatic t_order();
    rdy_mode = 2'b00;
    push(16'h00A1); push(16'h00B2); push(16'h00C3);
    check("R2 depth after 3 writes", depth(), 3);
    check("R10 rdy_n nonempty", int'(rdy_n), 0);
    pop(); check("R3 first", int'(rd_data), 16'h00A1);
    wr_vld = 1'b1; wr_data = 16'h00D4; rd_en = 1'b1; cyc(); wr_vld = 1'b0; rd_en = 1'b0;
    check("R2 simultaneous", depth(), 2);
    check("R3 second", int'(rd_data), 16'h00B2);
    pop(); check("R3 third", int'(rd_data), 16'h00C3);
    pop(); check("R3 fourth", int'(rd_data), 16'h00D4);
    check("R10 rdy_n empty", int'(rdy_n), 1);
  endtask

  task automatic t_underflow();
    pop();
    check("R5 data held", int'(rd_data), 16'h00D4);
    check("R5 udf_n", int'(udf_n), 0);
    check("R5 depth", depth(), 0);
    cyc();
    check("R6 udf sticky", int'(udf_n), 0);
    udf_clr = 1'b1; cyc(); udf_clr = 1'b0;
    check("R6 udf cleared", int'(udf_n), 1);
    rd_en = 1'b1; udf_clr = 1'b1; cyc(); rd_en = 1'b0; udf_clr = 1'b0;
    check("R6 set beats clear", int'(udf_n), 0);
    udf_clr = 1'b1; cyc(); udf_clr = 1'b0;
  endtask

  task automatic t_overflow();
    int bad = 0;
    for (int i = 0; i < 256; i++) push(16'(i + 16'h0100));
    check("R2 full depth_hi", int'(depth_hi), 1);
    check("R2 full depth_lo", int'(depth_lo), 0);
    check("R4 ovf_n before", int'(ovf_n), 1);
    push(16'h0999);
    check("R4 ovf_n", int'(ovf_n), 0);
    check("R4 depth held", depth(), 256);
    for (int i = 0; i < 256; i++) begin
      pop();
      if (rd_data != 16'(i + 16'h0100)) bad++;
    end
    check("R4 contents intact", bad, 0);
    check("R4 drained", depth(), 0);
    ovf_clr = 1'b1; cyc(); ovf_clr = 1'b0;
    check("R6 ovf cleared", int'(ovf_n), 1);
  endtask

  task automatic t_hyst();
    rdy_mode = 2'b11; thr_upper = 9'd4; thr_lower = 9'd1;
    push(1); push(2); push(3);
    check("R8 below upper", int'(rdy_n), 1);
    push(4);
    check("R7 at upper", int'(rdy_n), 0);
    pop();
    check("R8 hold at 3", int'(rdy_n), 0);
    pop();
    check("R8 hold at 2", int'(rdy_n), 0);
    pop();
    check("R8 rise at lower", int'(rdy_n), 1);
    push(5);
    check("R8 hold rising", int'(rdy_n), 1);
    pop(); pop();
  endtask

  task automatic t_zero_thr();
    thr_upper = 9'd0; thr_lower = 9'd1;
    for (int i = 0; i < 5; i++) push(16'(i));
    check("R9 upper disabled", int'(rdy_n), 1);
    thr_upper = 9'd3; thr_lower = 9'd0;
    push(16'h0055);
    check("R7 upper active", int'(rdy_n), 0);
    for (int i = 0; i < 6; i++) pop();
    check("R9 lower disabled", int'(rdy_n), 0);
    check("R9 drained", depth(), 0);
  endtask

  task automatic t_pdwn();
    push(16'h0011); push(16'h0022); pop();
    pdwn = 1'b1; cyc();
    check("R12 empty", depth(), 0);
    check("R12 rdy_n", int'(rdy_n), 1);
    check("R12 rd_data", int'(rd_data), 0);
    wr_vld = 1'b1; cyc(); wr_vld = 1'b0;
    check("R12 write ignored", depth(), 0);
    pdwn = 1'b0; rdy_mode = 2'b00;
  endtask

  task automatic t_disabled();
    push(16'h0077);
    fifo_en = 1'b0;
    push(16'h0088);
    check("R11 write ignored", depth(), 1);
    pop();
    check("R11 read ignored", depth(), 1);
    check("R11 data unchanged", int'(rd_data), 0);
    fifo_en = 1'b1;
    pop();
    fifo_en = 1'b0;
    pop();
    check("R11 no underflow", int'(udf_n), 1);
    fifo_en = 1'b1;
  endtask

  task automatic t_test_mode();
    test_en = 1'b1;
    pdwn = 1'b1; cyc(); pdwn = 1'b0;
    push(16'hABCD); push(16'hABCD); push(16'hABCD);
    pop(); check("R13 first", int'(rd_data), 1);
    pop(); check("R13 second", int'(rd_data), 2);
    pop(); check("R13 third", int'(rd_data), 3);
    pdwn = 1'b1; cyc(); pdwn = 1'b0;
    push(16'h1234); pop();
    check("R13 restart after pdwn", int'(rd_data), 1);
    test_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; pdwn = 1'b0; fifo_en = 1'b0; test_en = 1'b0;
    rdy_mode = 2'b00; thr_upper = '0; thr_lower = '0;
    wr_vld = 1'b0; wr_data = '0; rd_en = 1'b0; ovf_clr = 1'b0; udf_clr = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    t_reset();
    fifo_en = 1'b1;
    t_order();
    t_underflow();
    t_overflow();
    t_hyst();
    t_zero_thr();
    t_pdwn();
    t_disabled();
    t_test_mode();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule